// File: doc/BRIEF.md
# Register Result-Timing Scoreboard

This block sits beside the issue stage of an in-order pipeline and keeps one record per architectural register of the writes still in flight. Integer, floating-point, condition-code and vector registers share one flat table. Each class starts at a fixed base, and a register's slot is that base plus its index within the class. Each slot holds the following:
- a pending-write count;
- a count of writes whose arrival time is unknown;
- the cycle in which the newest write is expected;
- the execute sequence number of that newest writer;
- the functional unit that produces it.

When an instruction issues, its destinations are marked up. When it completes, the same destinations are cleared. Both updates take effect at the next rising clock edge.

Two queries run combinationally from the stored state. Both use one shared source-register list of up to three entries. The issue query decides whether the candidate may go this cycle and, if not, which source stopped it. Each source may start early by its own relative latency, unless the unit producing the value cannot forward. The dependency query reports the newest writer sequence number among the sources.

Top module: `reg_timing_scoreboard`

## Requirements
- R1: Register class codes are 0 for integer (slots 0 to 7), 1 for floating-point (slots 8 to 15), 2 for condition-code (slots 16 to 17) and 3 for vector (slots 18 to 21). A valid reference with class 4 to 7, or with an index at or beyond its class size, drives `err_class` high in the same cycle. Such a reference changes no slot, never blocks issue and is left out of the dependency result.
- R2: A markup destination `d` is selected by `mark_dst_vld[d]`, with class at bits `[3d+2:3d]` and index at bits `[3d+2:3d]` of the class and index buses. From the next cycle on, that slot's pending count is one higher, and its return cycle, writer sequence number and unit index equal `mark_ret`, `mark_seq` and `mark_fu`.
- R3: With `mark_unpred` high, each marked slot's unknown-timing count also rises by one. A valid tracked source whose unknown-timing count is nonzero blocks issue.
- R4: A clear decrements the pending count of each selected destination. It decrements the unknown-timing count only when `clr_unpred` is high.
- R5: A valid tracked source with a nonzero pending count blocks issue while `now + allowance < return cycle`. It stops blocking from the cycle in which the two sides are equal.
- R6: With `q_lat_n` equal to 0, every source's allowance is 0. Otherwise source `s` uses `q_lat[16s+15:16s]` when `s < q_lat_n`, and uses the entry at position `q_lat_n-1` when it does not.
- R7: If a slot's stored unit index is not 7 (code 7 means no known unit) and `q_nofwd` has that bit set, the allowance for that source is 0.
- R8: `can_issue` is low exactly when some source blocks. In that case `blk_idx` names the lowest-numbered blocking source.
- R9: `dep_seq` is the largest stored writer sequence number among valid tracked sources with a nonzero pending count, or 0 if there is none.
- R10: A markup and a clear of the same slot in one cycle are applied together, so each count changes by the difference of the two.
- R11: Counts stay within 0 to 7. An update that would exceed 7 leaves 7. A clear that would go below 0 leaves 0 and raises `underflow` in that same cycle.
- R12: A source whose pending count is zero never blocks on timing, whatever its stored return cycle; after reset, every source may issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mark_valid | input | 1 | Markup request this cycle |
| mark_dst_vld | input | 2 | Per-destination select for markup |
| mark_dst_cls | input | 6 | Class code per markup destination, 3 bits each |
| mark_dst_idx | input | 6 | In-class index per markup destination, 3 bits each |
| mark_unpred | input | 1 | Markup also counts unknown-timing writes |
| mark_ret | input | 16 | Expected return cycle of the marked writes |
| mark_seq | input | 16 | Execute sequence number of the marking instruction |
| mark_fu | input | 3 | Producing unit index, 7 for none |
| clr_valid | input | 1 | Clear request this cycle |
| clr_dst_vld | input | 2 | Per-destination select for clear |
| clr_dst_cls | input | 6 | Class code per clear destination |
| clr_dst_idx | input | 6 | In-class index per clear destination |
| clr_unpred | input | 1 | Clear also decrements unknown-timing counts |
| now | input | 16 | Current cycle number |
| q_src_vld | input | 3 | Source present flags for both queries |
| q_src_cls | input | 9 | Class code per source, 3 bits each |
| q_src_idx | input | 9 | In-class index per source, 3 bits each |
| q_lat_n | input | 2 | Number of supplied relative latencies |
| q_lat | input | 48 | Relative latency list, 16 bits per entry |
| q_nofwd | input | 7 | Per-unit flag: that unit cannot forward |
| can_issue | output | 1 | Candidate may issue this cycle |
| blk_idx | output | 2 | First blocking source when issue is refused |
| dep_seq | output | 16 | Newest writer sequence number among sources |
| err_class | output | 1 | Some valid reference names an untracked register |
| underflow | output | 1 | A clear would take a count below zero |

## Verification
All five outputs depend only on the present inputs and the stored table, so each is due in the same cycle as the stimulus that produces it. A markup or a clear shows in those outputs only from the cycle after the rising edge that takes it. The bench changes inputs on the falling edge and compares every output 2 ns later, before the next rising edge. It then applies that cycle's markup and clear to its own table only after the rising edge, so expected and actual values always refer to the same stored state.

// File: rtl/reg_timing_scoreboard.sv
module reg_timing_scoreboard #(
  parameter int NUM_INT = 8,
  parameter int NUM_FP  = 8,
  parameter int NUM_CC  = 2,
  parameter int NUM_VEC = 4,
  parameter int CLS_W   = 3,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 3,
  parameter int CYC_W   = 16,
  parameter int SEQ_W   = 16,
  parameter int FU_W    = 3,
  parameter int NUM_SRC = 3,
  parameter int NUM_DST = 2,
  localparam int NUM_FU = (1 << FU_W) - 1,
  localparam int LN_W   = $clog2(NUM_SRC + 1),
  localparam int SI_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mark_valid,
  input  logic [NUM_DST-1:0]       mark_dst_vld,
  input  logic [NUM_DST*CLS_W-1:0] mark_dst_cls,
  input  logic [NUM_DST*IDX_W-1:0] mark_dst_idx,
  input  logic                     mark_unpred,
  input  logic [CYC_W-1:0]         mark_ret,
  input  logic [SEQ_W-1:0]         mark_seq,
  input  logic [FU_W-1:0]          mark_fu,
  input  logic                     clr_valid,
  input  logic [NUM_DST-1:0]       clr_dst_vld,
  input  logic [NUM_DST*CLS_W-1:0] clr_dst_cls,
  input  logic [NUM_DST*IDX_W-1:0] clr_dst_idx,
  input  logic                     clr_unpred,
  input  logic [CYC_W-1:0]         now,
  input  logic [NUM_SRC-1:0]       q_src_vld,
  input  logic [NUM_SRC*CLS_W-1:0] q_src_cls,
  input  logic [NUM_SRC*IDX_W-1:0] q_src_idx,
  input  logic [LN_W-1:0]          q_lat_n,
  input  logic [NUM_SRC*CYC_W-1:0] q_lat,
  input  logic [NUM_FU-1:0]        q_nofwd,
  output logic                     can_issue,
  output logic [SI_W-1:0]          blk_idx,
  output logic [SEQ_W-1:0]         dep_seq,
  output logic                     err_class,
  output logic                     underflow
);
  localparam int OFF_FP  = NUM_INT;
  localparam int OFF_CC  = OFF_FP + NUM_FP;
  localparam int OFF_VEC = OFF_CC + NUM_CC;
  localparam int N       = OFF_VEC + NUM_VEC;
  localparam int EW      = $clog2(N);
  localparam int CMAX    = (1 << CNT_W) - 1;

  function automatic logic tracked(input logic [CLS_W-1:0] c, input logic [IDX_W-1:0] i);
    case (int'(c))
      0:       return int'(i) < NUM_INT;
      1:       return int'(i) < NUM_FP;
      2:       return int'(i) < NUM_CC;
      3:       return int'(i) < NUM_VEC;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [EW-1:0] slot(input logic [CLS_W-1:0] c, input logic [IDX_W-1:0] i);
    case (int'(c))
      1:       return EW'(OFF_FP + int'(i));
      2:       return EW'(OFF_CC + int'(i));
      3:       return EW'(OFF_VEC + int'(i));
      default: return EW'(int'(i));
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] sat(input int v);
    if (v < 0) return '0;
    if (v > CMAX) return CNT_W'(CMAX);
    return CNT_W'(v);
  endfunction

  logic [CNT_W-1:0] pend_q [N];
  logic [CNT_W-1:0] unp_q  [N];
  logic [CYC_W-1:0] ret_q  [N];
  logic [SEQ_W-1:0] seq_q  [N];
  logic [FU_W-1:0]  fu_q   [N];

  int          pn_a [N];
  int          un_a [N];
  logic [N-1:0] hit;
  logic [N-1:0] uf_e;

  always_comb begin
    for (int e = 0; e < N; e++) begin
      int inc, dec;
      inc = 0;
      dec = 0;
      for (int d = 0; d < NUM_DST; d++) begin
        if (mark_valid && mark_dst_vld[d] &&
            tracked(mark_dst_cls[d*CLS_W +: CLS_W], mark_dst_idx[d*IDX_W +: IDX_W]) &&
            slot(mark_dst_cls[d*CLS_W +: CLS_W], mark_dst_idx[d*IDX_W +: IDX_W]) == EW'(e))
          inc = inc + 1;
        if (clr_valid && clr_dst_vld[d] &&
            tracked(clr_dst_cls[d*CLS_W +: CLS_W], clr_dst_idx[d*IDX_W +: IDX_W]) &&
            slot(clr_dst_cls[d*CLS_W +: CLS_W], clr_dst_idx[d*IDX_W +: IDX_W]) == EW'(e))
          dec = dec + 1;
      end
      pn_a[e] = int'(pend_q[e]) + inc - dec;
      un_a[e] = int'(unp_q[e]) + (mark_unpred ? inc : 0) - (clr_unpred ? dec : 0);
      hit[e]  = inc > 0;
      uf_e[e] = (pn_a[e] < 0) || (un_a[e] < 0);
    end
  end

  assign underflow = |uf_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N; e++) begin
        pend_q[e] <= '0;
        unp_q[e]  <= '0;
        ret_q[e]  <= '0;
        seq_q[e]  <= '0;
        fu_q[e]   <= FU_W'(NUM_FU);
      end
    end else begin
      for (int e = 0; e < N; e++) begin
        pend_q[e] <= sat(pn_a[e]);
        unp_q[e]  <= sat(un_a[e]);
        if (hit[e]) begin
          ret_q[e] <= mark_ret;
          seq_q[e] <= mark_seq;
          fu_q[e]  <= mark_fu;
        end
      end
    end
  end

  logic [NUM_SRC-1:0] blk;

  always_comb begin
    int ln, sel;
    logic [EW-1:0]  e;
    logic [CYC_W-1:0] allow;
    logic ok;
    ln      = (int'(q_lat_n) > NUM_SRC) ? NUM_SRC : int'(q_lat_n);
    sel     = 0;
    e       = '0;
    allow   = '0;
    ok      = 1'b0;
    blk     = '0;
    dep_seq = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      ok    = tracked(q_src_cls[s*CLS_W +: CLS_W], q_src_idx[s*IDX_W +: IDX_W]);
      e     = slot(q_src_cls[s*CLS_W +: CLS_W], q_src_idx[s*IDX_W +: IDX_W]);
      allow = '0;
      if (ln != 0) begin
        sel   = (s < ln) ? s : ln - 1;
        allow = q_lat[sel*CYC_W +: CYC_W];
      end
      if (ok && q_src_vld[s]) begin
        if (fu_q[e] != FU_W'(NUM_FU) && q_nofwd[fu_q[e]])
          allow = '0;
        if (unp_q[e] != '0 ||
            (pend_q[e] != '0 && ({1'b0, now} + {1'b0, allow}) < {1'b0, ret_q[e]}))
          blk[s] = 1'b1;
        if (pend_q[e] != '0 && seq_q[e] > dep_seq)
          dep_seq = seq_q[e];
      end
    end
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    blk_idx = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (blk[s] && !found) begin
        blk_idx = SI_W'(s);
        found   = 1'b1;
      end
    end
  end

  assign can_issue = ~|blk;

  always_comb begin
    err_class = 1'b0;
    for (int d = 0; d < NUM_DST; d++) begin
      if (mark_valid && mark_dst_vld[d] &&
          !tracked(mark_dst_cls[d*CLS_W +: CLS_W], mark_dst_idx[d*IDX_W +: IDX_W]))
        err_class = 1'b1;
      if (clr_valid && clr_dst_vld[d] &&
          !tracked(clr_dst_cls[d*CLS_W +: CLS_W], clr_dst_idx[d*IDX_W +: IDX_W]))
        err_class = 1'b1;
    end
    for (int s = 0; s < NUM_SRC; s++) begin
      if (q_src_vld[s] && !tracked(q_src_cls[s*CLS_W +: CLS_W], q_src_idx[s*IDX_W +: IDX_W]))
        err_class = 1'b1;
    end
  end
endmodule

// File: rtl/reg_timing_scoreboard_sva.sv
module reg_timing_scoreboard_sva #(
  parameter int CLS_W   = 3,
  parameter int CYC_W   = 16,
  parameter int SEQ_W   = 16,
  parameter int FU_W    = 3,
  parameter int NUM_SRC = 3,
  parameter int NUM_DST = 2,
  parameter int IDX_W   = 3,
  localparam int NUM_FU = (1 << FU_W) - 1,
  localparam int LN_W   = $clog2(NUM_SRC + 1),
  localparam int SI_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mark_valid,
  input logic [NUM_DST-1:0]       mark_dst_vld,
  input logic [NUM_DST*CLS_W-1:0] mark_dst_cls,
  input logic                     clr_valid,
  input logic [CYC_W-1:0]         now,
  input logic [NUM_SRC-1:0]       q_src_vld,
  input logic [NUM_SRC*CLS_W-1:0] q_src_cls,
  input logic [NUM_SRC*IDX_W-1:0] q_src_idx,
  input logic [LN_W-1:0]          q_lat_n,
  input logic [NUM_SRC*CYC_W-1:0] q_lat,
  input logic [NUM_FU-1:0]        q_nofwd,
  input logic                     can_issue,
  input logic [SI_W-1:0]          blk_idx,
  input logic [SEQ_W-1:0]         dep_seq,
  input logic                     err_class,
  input logic                     underflow
);
  AST_BLOCKER_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !can_issue |-> q_src_vld[blk_idx]); // R8

  AST_EMPTY_QUERY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    q_src_vld == '0 |-> (can_issue && dep_seq == '0)); // R9

  AST_BAD_CLASS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_valid && mark_dst_vld[0] && int'(mark_dst_cls[CLS_W-1:0]) > 3) |-> err_class); // R1

  AST_UNDERFLOW_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> clr_valid); // R11

  AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!mark_valid && !clr_valid) && $stable(now) && $stable(q_src_vld) &&
     $stable(q_src_cls) && $stable(q_src_idx) && $stable(q_lat_n) &&
     $stable(q_lat) && $stable(q_nofwd))
    |-> ($stable(can_issue) && $stable(dep_seq))); // R2
endmodule

bind reg_timing_scoreboard reg_timing_scoreboard_sva #(
  .CLS_W(CLS_W), .CYC_W(CYC_W), .SEQ_W(SEQ_W), .FU_W(FU_W),
  .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .IDX_W(IDX_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .mark_valid(mark_valid), .mark_dst_vld(mark_dst_vld),
  .mark_dst_cls(mark_dst_cls), .clr_valid(clr_valid), .now(now),
  .q_src_vld(q_src_vld), .q_src_cls(q_src_cls), .q_src_idx(q_src_idx),
  .q_lat_n(q_lat_n), .q_lat(q_lat), .q_nofwd(q_nofwd), .can_issue(can_issue),
  .blk_idx(blk_idx), .dep_seq(dep_seq), .err_class(err_class), .underflow(underflow)
);

// File: tb/reg_timing_scoreboard_bench.sv
`timescale 1ns/1ps
module reg_timing_scoreboard_bench;
  localparam int NE = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mark_valid;
  logic [1:0]  mark_dst_vld;
  logic [5:0]  mark_dst_cls, mark_dst_idx;
  logic        mark_unpred;
  logic [15:0] mark_ret, mark_seq;
  logic [2:0]  mark_fu;
  logic        clr_valid;
  logic [1:0]  clr_dst_vld;
  logic [5:0]  clr_dst_cls, clr_dst_idx;
  logic        clr_unpred;
  logic [15:0] now;
  logic [2:0]  q_src_vld;
  logic [8:0]  q_src_cls, q_src_idx;
  logic [1:0]  q_lat_n;
  logic [47:0] q_lat;
  logic [6:0]  q_nofwd;
  logic        can_issue;
  logic [1:0]  blk_idx;
  logic [15:0] dep_seq;
  logic        err_class, underflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_pend[NE], m_unp[NE], m_ret[NE], m_seq[NE], m_fu[NE];
  int di[NE], dd[NE];

  always #5 clk = ~clk;

  reg_timing_scoreboard u_reg_timing_scoreboard (
    .clk(clk), .rst_n(rst_n), .mark_valid(mark_valid), .mark_dst_vld(mark_dst_vld),
    .mark_dst_cls(mark_dst_cls), .mark_dst_idx(mark_dst_idx), .mark_unpred(mark_unpred),
    .mark_ret(mark_ret), .mark_seq(mark_seq), .mark_fu(mark_fu), .clr_valid(clr_valid),
    .clr_dst_vld(clr_dst_vld), .clr_dst_cls(clr_dst_cls), .clr_dst_idx(clr_dst_idx),
    .clr_unpred(clr_unpred), .now(now), .q_src_vld(q_src_vld), .q_src_cls(q_src_cls),
    .q_src_idx(q_src_idx), .q_lat_n(q_lat_n), .q_lat(q_lat), .q_nofwd(q_nofwd),
    .can_issue(can_issue), .blk_idx(blk_idx), .dep_seq(dep_seq),
    .err_class(err_class), .underflow(underflow)
  );

  function automatic int bmap(int c, int i);
    int sizes[4] = '{8, 8, 2, 4};
    int base = 0;
    if (c > 3) return -1;
    for (int k = 0; k < c; k++) base += sizes[k];
    if (i >= sizes[c]) return -1;
    return base + i;
  endfunction

  task automatic calc_deltas(output bit bad);
    bad = 0;
    for (int e = 0; e < NE; e++) begin di[e] = 0; dd[e] = 0; end
    for (int d = 0; d < 2; d++) begin
      int em, ec;
      em = bmap(int'(mark_dst_cls[d*3 +: 3]), int'(mark_dst_idx[d*3 +: 3]));
      ec = bmap(int'(clr_dst_cls[d*3 +: 3]), int'(clr_dst_idx[d*3 +: 3]));
      if (mark_valid && mark_dst_vld[d]) begin
        if (em < 0) bad = 1; else di[em]++;
      end
      if (clr_valid && clr_dst_vld[d]) begin
        if (ec < 0) bad = 1; else dd[ec]++;
      end
    end
  endtask

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    bit bad;
    int e_can = 1, e_blk = 0, e_dep = 0, e_uf = 0;
    int ln = (int'(q_lat_n) > 3) ? 3 : int'(q_lat_n);
    calc_deltas(bad);
    for (int s = 0; s < 3; s++) begin
      int ent, allow;
      ent = bmap(int'(q_src_cls[s*3 +: 3]), int'(q_src_idx[s*3 +: 3]));
      if (q_src_vld[s] && ent < 0) bad = 1;
      if (q_src_vld[s] && ent >= 0) begin
        allow = 0;
        if (ln != 0) allow = int'(q_lat[((s < ln) ? s : ln - 1)*16 +: 16]);
        if (m_fu[ent] != 7 && q_nofwd[m_fu[ent]]) allow = 0;
        if ((m_unp[ent] > 0 || (m_pend[ent] > 0 && int'(now) + allow < m_ret[ent])) && e_can == 1) begin
          e_can = 0;
          e_blk = s;
        end
        if (m_pend[ent] > 0 && m_seq[ent] > e_dep) e_dep = m_seq[ent];
      end
    end
    for (int e = 0; e < NE; e++) begin
      if (m_pend[e] + di[e] - dd[e] < 0) e_uf = 1;
      if (m_unp[e] + (mark_unpred ? di[e] : 0) - (clr_unpred ? dd[e] : 0) < 0) e_uf = 1;
    end
    check(tag, "can_issue", int'(can_issue), e_can);
    if (e_can == 0) check(tag, "blk_idx", int'(blk_idx), e_blk);
    check(tag, "dep_seq", int'(dep_seq), e_dep);
    check(tag, "err_class", int'(err_class), int'(bad));
    check(tag, "underflow", int'(underflow), e_uf);
  endtask

  task automatic model_update();
    bit bad;
    calc_deltas(bad);
    for (int e = 0; e < NE; e++) begin
      int p, u;
      p = m_pend[e] + di[e] - dd[e];
      u = m_unp[e] + (mark_unpred ? di[e] : 0) - (clr_unpred ? dd[e] : 0);
      m_pend[e] = (p < 0) ? 0 : ((p > 7) ? 7 : p);
      m_unp[e]  = (u < 0) ? 0 : ((u > 7) ? 7 : u);
      if (di[e] > 0) begin
        m_ret[e] = int'(mark_ret);
        m_seq[e] = int'(mark_seq);
        m_fu[e]  = int'(mark_fu);
      end
    end
  endtask

  task automatic tick(string tag);
    #2;
    compare(tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    mark_valid = 0; mark_dst_vld = 0; mark_dst_cls = 0; mark_dst_idx = 0;
    mark_unpred = 0; mark_ret = 0; mark_seq = 0; mark_fu = 7;
    clr_valid = 0; clr_dst_vld = 0; clr_dst_cls = 0; clr_dst_idx = 0; clr_unpred = 0;
    q_src_vld = 0; q_src_cls = 0; q_src_idx = 0; q_lat_n = 0; q_lat = 0; q_nofwd = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired, got hang expected completion");
    finish_run();
  end

  initial begin
    for (int e = 0; e < NE; e++) begin
      m_pend[e] = 0; m_unp[e] = 0; m_ret[e] = 0; m_seq[e] = 0; m_fu[e] = 7;
    end
    idle_inputs();
    now = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    q_src_vld = 3'b001; q_src_cls[2:0] = 0; q_src_idx[2:0] = 3;
    tick("R12 reset state");

    mark_valid = 1; mark_dst_vld = 2'b11;
    mark_dst_cls = {3'd1, 3'd0}; mark_dst_idx = {3'd2, 3'd3};
    mark_ret = 20; mark_seq = 5; mark_fu = 1;
    tick("R2 markup");
    mark_valid = 0;
    now = 10; tick("R2 R5 R9 pending blocks");
    now = 19; tick("R5 one before return");
    now = 20; tick("R5 at return");

    q_src_vld = 3'b100; q_src_cls[8:6] = 0; q_src_idx[8:6] = 3;
    q_lat_n = 2; q_lat[15:0] = 0; q_lat[31:16] = 3;
    now = 17; tick("R6 last latency reused");
    now = 16; tick("R6 allowance edge");
    q_nofwd = 7'b0000010; now = 17; tick("R7 no forward");
    q_nofwd = 0; q_lat_n = 0; tick("R6 empty list");

    q_src_vld = 3'b011; q_src_cls[5:0] = {3'd0, 3'd1}; q_src_idx[5:0] = {3'd3, 3'd2};
    now = 0; tick("R8 first blocker");
    q_src_vld = 3'b110; tick("R8 later blocker");

    mark_valid = 1; mark_dst_vld = 2'b01; mark_dst_cls[2:0] = 0; mark_dst_idx[2:0] = 4;
    mark_unpred = 1; mark_ret = 0; mark_seq = 9; mark_fu = 2;
    tick("R3 unpredictable markup");
    mark_valid = 0; mark_unpred = 0;
    q_src_vld = 3'b001; q_src_cls[2:0] = 0; q_src_idx[2:0] = 4; now = 100;
    tick("R3 unknown timing blocks");
    clr_valid = 1; clr_dst_vld = 2'b01; clr_dst_cls[2:0] = 0; clr_dst_idx[2:0] = 4;
    tick("R4 clear without unpredictable");
    tick("R4 R11 clear below zero");
    clr_unpred = 1; tick("R4 R11 unpredictable clear");
    clr_valid = 0; clr_unpred = 0; tick("R4 R12 freed");

    q_src_idx[2:0] = 3; now = 0;
    mark_valid = 1; mark_dst_vld = 2'b01; mark_dst_cls[2:0] = 0; mark_dst_idx[2:0] = 3;
    mark_ret = 40; mark_seq = 11;
    clr_valid = 1; clr_dst_vld = 2'b01; clr_dst_cls[2:0] = 0; clr_dst_idx[2:0] = 3;
    tick("R10 same-cycle markup and clear");
    mark_valid = 0; clr_valid = 0; tick("R10 net unchanged");

    for (int k = 0; k < 9; k++) begin
      mark_valid = 1; mark_seq = 16'(20 + k); tick("R11 saturate");
    end
    mark_valid = 0;
    for (int k = 0; k < 7; k++) begin
      clr_valid = 1; tick("R11 drain");
    end
    clr_valid = 0; tick("R11 R12 empty after drain");

    mark_valid = 1; mark_dst_cls[2:0] = 5; tick("R1 unsupported class markup");
    mark_valid = 0; q_src_cls[2:0] = 2; q_src_idx[2:0] = 3; tick("R1 index beyond class");

    for (int c = 0; c < 4000; c++) begin
      mark_valid = 1'($urandom % 2);
      mark_dst_vld = 2'($urandom);
      clr_valid = 1'($urandom % 2);
      clr_dst_vld = 2'($urandom);
      for (int d = 0; d < 2; d++) begin
        mark_dst_cls[d*3 +: 3] = ($urandom % 10 == 0) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
        mark_dst_idx[d*3 +: 3] = 3'($urandom % 4);
        clr_dst_cls[d*3 +: 3]  = ($urandom % 10 == 0) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
        clr_dst_idx[d*3 +: 3]  = 3'($urandom % 4);
      end
      mark_unpred = ($urandom % 5 == 0);
      clr_unpred  = ($urandom % 3 == 0);
      now = 16'(now + 1);
      mark_ret = 16'(now + $urandom % 24);
      mark_seq = 16'(100 + c);
      mark_fu = 3'($urandom);
      q_src_vld = 3'($urandom);
      for (int s = 0; s < 3; s++) begin
        q_src_cls[s*3 +: 3] = ($urandom % 10 == 0) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
        q_src_idx[s*3 +: 3] = 3'($urandom % 4);
        q_lat[s*16 +: 16] = 16'($urandom % 8);
      end
      q_lat_n = 2'($urandom);
      q_nofwd = 7'($urandom);
      tick("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random");
    end
    finish_run();
  end
endmodule